// File: doc/BRIEF.md
# Trapping Instruction Transformer

When a load, store or atomic memory operation traps, the handler benefits from a compact form of the instruction that caused the trap. This block takes that instruction and returns a rewritten word suitable for the trap-instruction register. The rewritten word keeps the opcode, width code and data register. It drops the immediate offset of plain loads and stores. It puts into the base-register field the byte distance between the address that actually faulted and the address the instruction first computed.

A 16-bit compressed load or store is first widened to its 32-bit equivalent. Bit 1 of the result is then cleared, so the handler can tell that the original was compressed. If the fault came from an implicit page-table walk rather than from the instruction itself, the block returns one of four fixed pseudo-codes instead. The pseudo-code records whether the walk read or wrote and whether the walk used 32-bit or 64-bit entries. A result of zero means no transformed instruction is offered.

The result is registered once. A request presented with `req_vld_i` in one cycle appears on `tinst_o` with `tinst_vld_o` in the next cycle, and the register keeps its value between requests.

Top module: `trap_insn_xform`

## Requirements
- R1: While `rst_n` is low, `tinst_o` reads 0 and `tinst_vld_o` reads 0.
- R2: `tinst_vld_o` equals `req_vld_i` of the previous cycle. `tinst_o` is loaded only in a cycle where `req_vld_i` is high, and otherwise keeps its value.
- R3: This requirement covers uncompressed integer loads (opcode 0000011, any width code except 3'b111) and FP loads (opcode 0000111, width code 010, 011 or 100). Each yields {12'b0, offset, width code, rd, opcode}.
- R4: This requirement covers uncompressed integer stores (opcode 0100011, width code 000 to 011) and FP stores (opcode 0100111, width code 010, 011 or 100). Each yields {7'b0, rs2, offset, width code, 5'b0, opcode}.
- R5: Atomics, LR and SC (opcode 0101111, width code 010 or 011) keep every bit except bits 19:15, which are replaced by the offset.
- R6: Any other uncompressed opcode, or a listed opcode with an unlisted width code, yields 0.
- R7: Compressed loads and stores of quadrants 00 and 10 are widened to the matching 32-bit form and then rewritten as in R3/R4 with bit 1 cleared. The forms are word and double loads and stores, FP double loads and stores, and their stack-pointer variants. Bits 31:16 of `insn_i` are ignored when `insn_cmp_i` is high.
- R8: Any other compressed encoding yields 0. This includes a stack-pointer word or double load with destination register 0.
- R9: A nonzero non-pseudo result has bits 1:0 = 2'b11 for an uncompressed original and 2'b01 for a compressed one.
- R10: When `pt_fault_i` is high, the pseudo-code takes priority over the instruction. A read gives 0x00002000 for a 32-bit walk (`pt_wide_i` low) and 0x00003000 for a 64-bit walk (`pt_wide_i` high). A pseudo-code has bits 1:0 = 2'b00.
- R11: With `SUPPORT_AD_UPDATE`=1, a walk write (`pt_write_i` high) gives 0x00002020 or 0x00003020. With `SUPPORT_AD_UPDATE`=0, a walk write gives the read code.
- R12: For every nonzero non-pseudo result, bits 19:15 equal `addr_off_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld_i | input | 1 | Request strobe, loads the result register |
| insn_i | input | 32 | Trapping instruction (low half used when compressed) |
| insn_cmp_i | input | 1 | Instruction is a 16-bit compressed encoding |
| addr_off_i | input | 5 | Faulting address minus original address |
| pt_fault_i | input | 1 | Fault arose during an implicit page-table access |
| pt_write_i | input | 1 | That implicit access was a write |
| pt_wide_i | input | 1 | That implicit access used 64-bit entries |
| tinst_vld_o | output | 1 | Result register was loaded in the previous cycle |
| tinst_o | output | 32 | Transformed instruction, pseudo-code or zero |

## Verification
The rewrite is exercised with integer, FP, byte and double loads and stores that carry nonzero immediates, negative immediates and varied register numbers. A wrong field splice or a missed immediate clear therefore shows as a distinct bit pattern. Atomics with aq/rl bits and nonzero rs2 confirm that only bits 19:15 change. Offsets of 0 and of several nonzero values separate a correct offset insertion from a stuck field.

Compressed quadrant-00 and stack-pointer forms check the register widening and bit-1 clearing. Junk in the upper half shows whether those bits leak through. The rd=0 stack-pointer load and a quadrant-01 code confirm rejection. The four pseudo-codes are tried on two instances, one with and one without the write code, and a real instruction is supplied at the same time to show pseudo priority.

// File: rtl/tinst_pkg.sv
package tinst_pkg;

  localparam int INSN_W = 32;
  localparam int OFF_W  = 5;

  localparam logic [6:0] OP_LOAD   = 7'b0000011;
  localparam logic [6:0] OP_FLOAD  = 7'b0000111;
  localparam logic [6:0] OP_STORE  = 7'b0100011;
  localparam logic [6:0] OP_FSTORE = 7'b0100111;
  localparam logic [6:0] OP_AMO    = 7'b0101111;

  localparam logic [2:0] W_WORD = 3'b010;
  localparam logic [2:0] W_DBL  = 3'b011;
  localparam logic [2:0] W_QUAD = 3'b100;

  // implicit walk codes: funct3 selects entry size, bit 5 marks a write
  localparam logic [INSN_W-1:0] PSEUDO_RD32 = 32'h0000_2000;
  localparam logic [INSN_W-1:0] PSEUDO_RD64 = 32'h0000_3000;
  localparam logic [INSN_W-1:0] PSEUDO_WRBIT = 32'h0000_0020;

  function automatic logic [INSN_W-1:0] mk_load(logic [6:0] op, logic [2:0] f3,
                                                logic [4:0] rd, logic [OFF_W-1:0] off);
    return {12'b0, off, f3, rd, op};
  endfunction

  function automatic logic [INSN_W-1:0] mk_store(logic [6:0] op, logic [2:0] f3,
                                                 logic [4:0] rs2, logic [OFF_W-1:0] off);
    return {7'b0, rs2, off, f3, 5'b0, op};
  endfunction

  function automatic logic [INSN_W-1:0] mk_amo(logic [INSN_W-1:0] insn, logic [OFF_W-1:0] off);
    return {insn[31:20], off, insn[14:0]};
  endfunction

  function automatic logic fp_width_ok(logic [2:0] f3);
    return (f3 == W_WORD) || (f3 == W_DBL) || (f3 == W_QUAD);
  endfunction

  function automatic logic load_ok(logic [6:0] op, logic [2:0] f3);
    if (op == OP_LOAD)  return f3 != 3'b111;
    if (op == OP_FLOAD) return fp_width_ok(f3);
    return 1'b0;
  endfunction

  function automatic logic store_ok(logic [6:0] op, logic [2:0] f3);
    if (op == OP_STORE)  return f3[2] == 1'b0;
    if (op == OP_FSTORE) return fp_width_ok(f3);
    return 1'b0;
  endfunction

  function automatic logic amo_ok(logic [6:0] op, logic [2:0] f3);
    return (op == OP_AMO) && ((f3 == W_WORD) || (f3 == W_DBL));
  endfunction

endpackage

// File: rtl/tinst_full_xform.sv
module tinst_full_xform
  import tinst_pkg::*;
(
  input  logic [INSN_W-1:0] insn_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [INSN_W-1:0] word_o,
  output logic              hit_ld_o,
  output logic              hit_st_o,
  output logic              hit_amo_o
);
  logic [6:0] op;
  logic [2:0] f3;

  assign op = insn_i[6:0];
  assign f3 = insn_i[14:12];

  assign hit_ld_o  = load_ok(op, f3);
  assign hit_st_o  = store_ok(op, f3);
  assign hit_amo_o = amo_ok(op, f3);

  always_comb begin
    word_o = '0;
    if (hit_ld_o)       word_o = mk_load(op, f3, insn_i[11:7], off_i);
    else if (hit_st_o)  word_o = mk_store(op, f3, insn_i[24:20], off_i);
    else if (hit_amo_o) word_o = mk_amo(insn_i, off_i);
  end
endmodule

// File: rtl/tinst_rvc_xform.sv
module tinst_rvc_xform
  import tinst_pkg::*;
(
  input  logic [15:0]       half_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [INSN_W-1:0] word_o,
  output logic              hit_o
);
  logic [1:0] quad;
  logic [2:0] cf3;
  logic [4:0] reg_short;
  logic [4:0] reg_long_rd;
  logic [4:0] reg_long_rs2;

  logic       is_ld, is_st;
  logic [6:0] xop;
  logic [2:0] xf3;
  logic [4:0] xreg;

  assign quad         = half_i[1:0];
  assign cf3          = half_i[15:13];
  assign reg_short    = {2'b01, half_i[4:2]};
  assign reg_long_rd  = half_i[11:7];
  assign reg_long_rs2 = half_i[6:2];

  always_comb begin
    is_ld = 1'b0;
    is_st = 1'b0;
    xop   = OP_LOAD;
    xf3   = W_WORD;
    xreg  = '0;
    if (quad == 2'b00 || quad == 2'b10) begin
      xreg = (quad == 2'b00) ? reg_short : (cf3[2] ? reg_long_rs2 : reg_long_rd);
      unique case (cf3)
        3'b001: begin is_ld = 1'b1; xop = OP_FLOAD;  xf3 = W_DBL;  end
        3'b010: begin is_ld = 1'b1; xop = OP_LOAD;   xf3 = W_WORD; end
        3'b011: begin is_ld = 1'b1; xop = OP_LOAD;   xf3 = W_DBL;  end
        3'b101: begin is_st = 1'b1; xop = OP_FSTORE; xf3 = W_DBL;  end
        3'b110: begin is_st = 1'b1; xop = OP_STORE;  xf3 = W_WORD; end
        3'b111: begin is_st = 1'b1; xop = OP_STORE;  xf3 = W_DBL;  end
        default: ;
      endcase
      // stack-pointer integer loads into x0 are reserved encodings
      if (quad == 2'b10 && xop == OP_LOAD && is_ld && reg_long_rd == 5'd0)
        is_ld = 1'b0;
    end
  end

  assign hit_o = is_ld || is_st;

  always_comb begin
    word_o = '0;
    if (is_ld)      word_o = mk_load(xop, xf3, xreg, off_i);
    else if (is_st) word_o = mk_store(xop, xf3, xreg, off_i);
    word_o[1] = 1'b0;
  end
endmodule

// File: rtl/tinst_pseudo_gen.sv
module tinst_pseudo_gen
  import tinst_pkg::*;
#(
  parameter bit SUPPORT_AD_UPDATE = 1'b1
) (
  input  logic              write_i,
  input  logic              wide_i,
  output logic [INSN_W-1:0] code_o
);
  logic [INSN_W-1:0] base;
  assign base = wide_i ? PSEUDO_RD64 : PSEUDO_RD32;

  generate
    if (SUPPORT_AD_UPDATE) begin : g_wr
      assign code_o = write_i ? (base | PSEUDO_WRBIT) : base;
    end else begin : g_rd_only
      logic unused_wr;
      assign unused_wr = write_i;
      assign code_o    = base;
    end
  endgenerate
endmodule

// File: rtl/trap_insn_xform.sv
module trap_insn_xform
  import tinst_pkg::*;
#(
  parameter bit SUPPORT_AD_UPDATE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_vld_i,
  input  logic [INSN_W-1:0] insn_i,
  input  logic              insn_cmp_i,
  input  logic [OFF_W-1:0]  addr_off_i,
  input  logic              pt_fault_i,
  input  logic              pt_write_i,
  input  logic              pt_wide_i,
  output logic              tinst_vld_o,
  output logic [INSN_W-1:0] tinst_o
);
  logic [INSN_W-1:0] full_word, rvc_word, pseudo_word, next_word;
  logic              full_hit_ld, full_hit_st, full_hit_amo, rvc_hit;
  logic              full_hit, use_full, use_rvc;

  tinst_full_xform u_full (
    .insn_i    (insn_i),
    .off_i     (addr_off_i),
    .word_o    (full_word),
    .hit_ld_o  (full_hit_ld),
    .hit_st_o  (full_hit_st),
    .hit_amo_o (full_hit_amo)
  );

  tinst_rvc_xform u_rvc (
    .half_i (insn_i[15:0]),
    .off_i  (addr_off_i),
    .word_o (rvc_word),
    .hit_o  (rvc_hit)
  );

  tinst_pseudo_gen #(.SUPPORT_AD_UPDATE(SUPPORT_AD_UPDATE)) u_pseudo (
    .write_i (pt_write_i),
    .wide_i  (pt_wide_i),
    .code_o  (pseudo_word)
  );

  assign full_hit = full_hit_ld | full_hit_st | full_hit_amo;
  assign use_full = !pt_fault_i && !insn_cmp_i && full_hit;
  assign use_rvc  = !pt_fault_i &&  insn_cmp_i && rvc_hit;

  always_comb begin
    next_word = '0;
    if (pt_fault_i)    next_word = pseudo_word;
    else if (use_rvc)  next_word = rvc_word;
    else if (use_full) next_word = full_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tinst_o     <= '0;
      tinst_vld_o <= 1'b0;
    end else begin
      tinst_vld_o <= req_vld_i;
      if (req_vld_i) tinst_o <= next_word;
    end
  end
endmodule

// File: rtl/trap_insn_xform_chk.sv
module trap_insn_xform_chk
  import tinst_pkg::*;
#(
  parameter bit SUPPORT_AD_UPDATE = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_vld_i,
  input logic              insn_cmp_i,
  input logic [OFF_W-1:0]  addr_off_i,
  input logic              pt_fault_i,
  input logic              pt_write_i,
  input logic              tinst_vld_o,
  input logic [INSN_W-1:0] tinst_o,
  input logic              full_hit_ld,
  input logic              full_hit_st,
  input logic              full_hit_amo
);
  p_vld_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld_i |=> tinst_vld_o);
  p_vld_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld_i |=> !tinst_vld_o);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld_i |=> $stable(tinst_o));

  p_class_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({full_hit_ld, full_hit_st, full_hit_amo}));

  p_low_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tinst_vld_o && !$past(pt_fault_i) && !$past(insn_cmp_i) && (tinst_o != '0)
      |-> tinst_o[1:0] == 2'b11);
  p_low_rvc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tinst_vld_o && !$past(pt_fault_i) && $past(insn_cmp_i) && (tinst_o != '0)
      |-> tinst_o[1:0] == 2'b01);

  p_pseudo_shape_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tinst_vld_o && $past(pt_fault_i)
      |-> (tinst_o[1:0] == 2'b00) && (tinst_o[31:14] == '0) && tinst_o[13]);

  p_offset_r12: assert property (@(posedge clk) disable iff (!rst_n)
    tinst_vld_o && !$past(pt_fault_i) && (tinst_o != '0)
      |-> tinst_o[19:15] == $past(addr_off_i));

  generate
    if (SUPPORT_AD_UPDATE) begin : g_wr
      p_write_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tinst_vld_o && $past(pt_fault_i) |-> tinst_o[5] == $past(pt_write_i));
    end else begin : g_rd
      p_no_write_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tinst_vld_o && $past(pt_fault_i) |-> !tinst_o[5]);
    end
  endgenerate
endmodule

bind trap_insn_xform trap_insn_xform_chk #(.SUPPORT_AD_UPDATE(SUPPORT_AD_UPDATE)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_vld_i    (req_vld_i),
  .insn_cmp_i   (insn_cmp_i),
  .addr_off_i   (addr_off_i),
  .pt_fault_i   (pt_fault_i),
  .pt_write_i   (pt_write_i),
  .tinst_vld_o  (tinst_vld_o),
  .tinst_o      (tinst_o),
  .full_hit_ld  (full_hit_ld),
  .full_hit_st  (full_hit_st),
  .full_hit_amo (full_hit_amo)
);

// File: tb/trap_insn_xform_bench.sv
module trap_insn_xform_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_vld_i = 1'b0;
  logic [31:0] insn_i = '0;
  logic        insn_cmp_i = 1'b0;
  logic [4:0]  addr_off_i = '0;
  logic        pt_fault_i = 1'b0;
  logic        pt_write_i = 1'b0;
  logic        pt_wide_i = 1'b0;
  logic        tinst_vld_o, noad_vld;
  logic [31:0] tinst_o, noad_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  trap_insn_xform u_trap_insn_xform (
    .clk(clk), .rst_n(rst_n), .req_vld_i(req_vld_i), .insn_i(insn_i),
    .insn_cmp_i(insn_cmp_i), .addr_off_i(addr_off_i), .pt_fault_i(pt_fault_i),
    .pt_write_i(pt_write_i), .pt_wide_i(pt_wide_i),
    .tinst_vld_o(tinst_vld_o), .tinst_o(tinst_o));

  trap_insn_xform #(.SUPPORT_AD_UPDATE(1'b0)) u_noad (
    .clk(clk), .rst_n(rst_n), .req_vld_i(req_vld_i), .insn_i(insn_i),
    .insn_cmp_i(insn_cmp_i), .addr_off_i(addr_off_i), .pt_fault_i(pt_fault_i),
    .pt_write_i(pt_write_i), .pt_wide_i(pt_wide_i),
    .tinst_vld_o(noad_vld), .tinst_o(noad_out));

  typedef struct packed {
    logic        cmp;
    logic [4:0]  off;
    logic [31:0] insn;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 22;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 5'd0, 32'h0085_2283, 32'h0000_2283, 4'd3},  // R3 LW
    '{1'b0, 5'd3, 32'h0085_2283, 32'h0001_A283, 4'd12}, // R12 LW offset 3
    '{1'b0, 5'd0, 32'hFFF1_4083, 32'h0000_4083, 4'd3},  // R3 LBU negative imm
    '{1'b0, 5'd5, 32'h0100_BF83, 32'h0002_BF83, 4'd3},  // R3 LD rd31
    '{1'b0, 5'd0, 32'h0184_3107, 32'h0000_3107, 4'd3},  // R3 FLD
    '{1'b0, 5'd0, 32'h0000_7003, 32'h0000_0000, 4'd6},  // R6 load width 111
    '{1'b0, 5'd2, 32'h0075_A623, 32'h0071_2023, 4'd4},  // R4 SW
    '{1'b0, 5'd0, 32'hFE31_3C23, 32'h0030_3023, 4'd4},  // R4 SD negative imm
    '{1'b0, 5'd1, 32'h0042_A027, 32'h0040_A027, 4'd4},  // R4 FSW
    '{1'b0, 5'd0, 32'h0074_232F, 32'h0070_232F, 4'd5},  // R5 AMOADD.W
    '{1'b0, 5'd4, 32'h0074_232F, 32'h0072_232F, 4'd5},  // R5 AMOADD.W offset 4
    '{1'b0, 5'd0, 32'h1405_B52F, 32'h1400_352F, 4'd5},  // R5 LR.D aq
    '{1'b0, 5'd7, 32'h1AD7_262F, 32'h1AD3_A62F, 4'd5},  // R5 SC.W rl
    '{1'b0, 5'd0, 32'h0010_8093, 32'h0000_0000, 4'd6},  // R6 ADDI
    '{1'b0, 5'd0, 32'h0000_002F, 32'h0000_0000, 4'd6},  // R6 AMO width 000
    '{1'b1, 5'd0, 32'h0000_4144, 32'h0000_2481, 4'd7},  // R7 C.LW
    '{1'b1, 5'd2, 32'hDEAD_4144, 32'h0001_2481, 4'd7},  // R7 C.LW, upper junk
    '{1'b1, 5'd0, 32'h0000_E380, 32'h0080_3021, 4'd7},  // R7 C.SD
    '{1'b1, 5'd0, 32'h0000_2008, 32'h0000_3505, 4'd7},  // R7 C.FLD
    '{1'b1, 5'd6, 32'h0000_6282, 32'h0003_3281, 4'd9},  // R9 C.LDSP
    '{1'b1, 5'd0, 32'h0000_C006, 32'h0010_2021, 4'd7},  // R7 C.SWSP
    '{1'b1, 5'd0, 32'h0000_4002, 32'h0000_0000, 4'd8}   // R8 C.LWSP rd0
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic issue(input logic cmp, input logic [4:0] off, input logic [31:0] insn,
                       input logic pf, input logic pw, input logic wide);
    @(negedge clk);
    req_vld_i = 1'b1; insn_cmp_i = cmp; addr_off_i = off; insn_i = insn;
    pt_fault_i = pf; pt_write_i = pw; pt_wide_i = wide;
    @(negedge clk);
    req_vld_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset data", tinst_o, 32'h0);
    check("R1 reset valid", {31'b0, tinst_vld_o}, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      issue(VEC[i].cmp, VEC[i].off, VEC[i].insn, 1'b0, 1'b0, 1'b0);
      check($sformatf("R%0d vector %0d", VEC[i].req, i), tinst_o, VEC[i].exp);
    end

    // R8 quadrant-01 code is rejected
    issue(1'b1, 5'd0, 32'h0000_0505, 1'b0, 1'b0, 1'b0);
    check("R8 C.ADDI", tinst_o, 32'h0);

    // R2 valid timing and hold
    issue(1'b0, 5'd0, 32'h0085_2283, 1'b0, 1'b0, 1'b0);
    check("R2 valid one cycle later", {31'b0, tinst_vld_o}, 32'h1);
    insn_i = 32'h0075_A623; addr_off_i = 5'd9;
    @(negedge clk);
    check("R2 valid drops", {31'b0, tinst_vld_o}, 32'h0);
    check("R2 output held", tinst_o, 32'h0000_2283);

    // R10 pseudo codes, instruction also present to show priority
    issue(1'b0, 5'd3, 32'h0085_2283, 1'b1, 1'b0, 1'b0);
    check("R10 read narrow", tinst_o, 32'h0000_2000);
    issue(1'b0, 5'd0, 32'h0085_2283, 1'b1, 1'b0, 1'b1);
    check("R10 read wide", tinst_o, 32'h0000_3000);
    issue(1'b1, 5'd0, 32'h0000_4144, 1'b1, 1'b1, 1'b0);
    check("R11 write narrow", tinst_o, 32'h0000_2020);
    check("R11 write narrow, no A/D update", noad_out, 32'h0000_2000);
    issue(1'b0, 5'd0, 32'h0000_0000, 1'b1, 1'b1, 1'b1);
    check("R11 write wide", tinst_o, 32'h0000_3020);
    check("R11 write wide, no A/D update", noad_out, 32'h0000_3000);
    check("R11 no A/D valid", {31'b0, noad_vld}, 32'h1);

    // R1 reset clears a loaded value
    issue(1'b0, 5'd0, 32'h0085_2283, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset clears", tinst_o, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

endmodule